// File: doc/BRIEF.md
# Burst Sample Buffer with Status Register

This block sits between a sampling converter core and a host processor. Each time the core finishes a conversion it raises a one-cycle valid strobe. The block then stores the 12-bit result code and an out-of-range flag as one 13-bit entry in an eight-entry ring buffer. Because results are buffered, the host can let several samples pile up and collect them in one burst. This saves one interrupt per sample.

The host reaches the block over a small parallel bus. The bus has active-low chip-select, read and write strobes and one address bit. With the address bit at 0, a read pops the oldest sample. With the address bit at 1, a read returns a status word and a write sets the programmed fill length. The interrupt output is high while the buffer holds at least that many entries. A sample that arrives when the buffer is already at its length replaces the oldest entry and sets a sticky overflow flag.

Top module: `sample_burst_fifo`

## Requirements
- R1: After reset the buffer is empty, the interrupt is low, the read bus `rdData` is 0, the overflow flag is clear and the length code is 7 (length eight).
- R2: A bus read is a cycle with `csN` and `rdN` low. Its result appears on `rdData` after that clock edge and holds until the next read. A data read (`addr`=0) of a non-empty buffer returns the oldest entry as {3'b0, oor, code[11:0]} and removes it, so samples come out in arrival order.
- R3: A status read (`addr`=1) returns bits [3:0] fill count, [4] empty, [5] out-of-range flag of the oldest entry (0 when empty), [6] overflow flag, [9:7] length code, [15:10] zero.
- R4: A write (`csN` and `wrN` low, `addr`=1) loads `cfgData` as the length code; the programmed length is code+1. A write with `addr`=0 changes nothing.
- R5: `irq` is high exactly when the fill count is at least the programmed length.
- R6: A sample arriving with no data read in the same cycle, while the fill count is at or above the length, discards the oldest entry, keeps the count and sets the overflow flag.
- R7: A status read returns the overflow flag and then clears it, unless an overwrite happens in the same cycle, which leaves the flag set.
- R8: A data read of an empty buffer leaves `rdData` and the count unchanged.
- R9: A sample and a data read in the same cycle on a non-empty buffer return the oldest entry, store the new one, keep the count and do not set overflow.
- R10: All 4096 result codes pass through unchanged; code 0xFFF is kept distinct from code 0x000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| resValid | input | 1 | One-cycle strobe: conversion result ready |
| resCode | input | 12 | Conversion result code |
| resOor | input | 1 | Result is out of range |
| csN | input | 1 | Active-low chip select |
| rdN | input | 1 | Active-low read strobe |
| wrN | input | 1 | Active-low write strobe |
| addr | input | 1 | 0 = sample data port, 1 = status/control |
| cfgData | input | 3 | Length code written to the control register |
| rdData | output | 16 | Registered read result |
| irq | output | 1 | Fill count at or above the programmed length |

## Verification
The bench runs every result code through the buffer, with the out-of-range bit varying. A datapath that dropped a bit or folded 0xFFF onto 0x000 would return the wrong code. For each of the eight lengths it pushes two samples past the length. A design that overwrote at the wrong depth, advanced only one pointer, or raised the interrupt one count early or late would show a wrong count, a wrong flag or a wrong order on read-out. The bench also covers three more corner cases:
- A read of an empty buffer, which must not wrap the pointers.
- A sample and a read in the same cycle, which must not be taken as an overflow.
- A status read in the same cycle as an overwrite, where the set must win over the clear.

// File: rtl/sample_burst_fifo_pkg.sv
package sample_burst_fifo_pkg;
  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic push;      // store incoming sample at write pointer
    logic pop;       // advance read pointer and load data word
    logic drop;      // discard oldest entry (overwrite case)
    logic loadStat;  // load status word onto read bus
  } sfStrb_t;
endpackage

// File: rtl/sample_burst_fifo_ctrl.sv
module sample_burst_fifo_ctrl
  import sample_burst_fifo_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             resValid,
  input  logic             csN,
  input  logic             rdN,
  input  logic             wrN,
  input  logic             addr,
  input  logic [PTR_W-1:0] cfgData,
  output sfStrb_t          strb,
  output logic [CNT_W-1:0] fillCount,
  output logic             ovfFlag,
  output logic [PTR_W-1:0] lenCode,
  output logic             irq
);
  logic             dataRd, statRd, cfgWr;
  logic [CNT_W-1:0] lenVal;

  assign dataRd = !csN && !rdN && !addr;
  assign statRd = !csN && !rdN && addr;
  assign cfgWr  = !csN && !wrN && addr;
  assign lenVal = CNT_W'(lenCode) + CNT_W'(1);

  always_comb begin
    strb.push     = resValid;
    strb.pop      = dataRd && (fillCount != '0);
    strb.drop     = resValid && !strb.pop && (fillCount >= lenVal);
    strb.loadStat = statRd;
  end

  assign irq = fillCount >= lenVal;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fillCount <= '0;
      ovfFlag   <= 1'b0;
      lenCode   <= PTR_W'(DEPTH - 1);
    end else begin
      if (strb.push && !strb.pop && !strb.drop)
        fillCount <= fillCount + CNT_W'(1);
      else if (strb.pop && !strb.push)
        fillCount <= fillCount - CNT_W'(1);

      if (strb.drop)
        ovfFlag <= 1'b1;
      else if (statRd)
        ovfFlag <= 1'b0;

      if (cfgWr)
        lenCode <= cfgData;
    end
  end
endmodule

// File: rtl/sample_burst_fifo_data.sv
module sample_burst_fifo_data
  import sample_burst_fifo_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int RES_W = 12,
  parameter int BUS_W = 16,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int ENT_W = RES_W + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  sfStrb_t          strb,
  input  logic [RES_W-1:0] resCode,
  input  logic             resOor,
  input  logic [CNT_W-1:0] fillCount,
  input  logic             ovfFlag,
  input  logic [PTR_W-1:0] lenCode,
  output logic [BUS_W-1:0] rdData
);
  logic [ENT_W-1:0] slot [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [ENT_W-1:0] headEntry;
  logic             isEmpty, headOor;
  logic [BUS_W-1:0] statWord;

  for (genvar g = 0; g < DEPTH; g++) begin : gSlot
    always_ff @(posedge clk) begin
      if (strb.push && (wrPtr == PTR_W'(g)))
        slot[g] <= {resOor, resCode};
    end
  end

  assign headEntry = slot[rdPtr];
  assign isEmpty   = (fillCount == '0);
  assign headOor   = !isEmpty && headEntry[RES_W];
  assign statWord  = BUS_W'({lenCode, ovfFlag, headOor, isEmpty, fillCount});

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr  <= '0;
      rdPtr  <= '0;
      rdData <= '0;
    end else begin
      if (strb.push)
        wrPtr <= wrPtr + PTR_W'(1);
      if (strb.pop || strb.drop)
        rdPtr <= rdPtr + PTR_W'(1);
      if (strb.loadStat)
        rdData <= statWord;
      else if (strb.pop)
        rdData <= BUS_W'(headEntry);
    end
  end
endmodule

// File: rtl/sample_burst_fifo.sv
module sample_burst_fifo
  import sample_burst_fifo_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int RES_W = 12,
  parameter int BUS_W = 16,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             resValid,
  input  logic [RES_W-1:0] resCode,
  input  logic             resOor,
  input  logic             csN,
  input  logic             rdN,
  input  logic             wrN,
  input  logic             addr,
  input  logic [PTR_W-1:0] cfgData,
  output logic [BUS_W-1:0] rdData,
  output logic             irq
);
  sfStrb_t          strb;
  logic [CNT_W-1:0] fillCount;
  logic             ovfFlag;
  logic [PTR_W-1:0] lenCode;

  sample_burst_fifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .resValid(resValid), .csN(csN), .rdN(rdN),
    .wrN(wrN), .addr(addr), .cfgData(cfgData), .strb(strb),
    .fillCount(fillCount), .ovfFlag(ovfFlag), .lenCode(lenCode), .irq(irq)
  );

  sample_burst_fifo_data #(.DEPTH(DEPTH), .RES_W(RES_W), .BUS_W(BUS_W)) u_data (
    .clk(clk), .rstN(rstN), .strb(strb), .resCode(resCode), .resOor(resOor),
    .fillCount(fillCount), .ovfFlag(ovfFlag), .lenCode(lenCode), .rdData(rdData)
  );
endmodule

// File: rtl/sample_burst_fifo_chk.sv
module sample_burst_fifo_chk #(
  parameter int DEPTH = 8,
  parameter int BUS_W = 16,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic             resValid,
  input logic             csN,
  input logic             rdN,
  input logic             addr,
  input logic [CNT_W-1:0] fillCount,
  input logic             ovfFlag,
  input logic [PTR_W-1:0] lenCode,
  input logic [BUS_W-1:0] rdData
);
  logic             dRd, sRd, popping, overwr;
  logic [CNT_W-1:0] lenVal;
  assign dRd     = !csN && !rdN && !addr;
  assign sRd     = !csN && !rdN && addr;
  assign lenVal  = CNT_W'(lenCode) + CNT_W'(1);
  assign popping = dRd && (fillCount != '0);
  assign overwr  = resValid && !popping && (fillCount >= lenVal);

  assert_count_bound_R6: assert property (@(posedge clk) disable iff (!rstN)
    fillCount <= CNT_W'(DEPTH));

  assert_push_grows_R2: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && !dRd && fillCount < lenVal) |=> fillCount == $past(fillCount) + CNT_W'(1));

  assert_overwrite_R6: assert property (@(posedge clk) disable iff (!rstN)
    overwr |=> ovfFlag && $stable(fillCount));

  assert_ovf_clear_R7: assert property (@(posedge clk) disable iff (!rstN)
    (sRd && !overwr) |=> !ovfFlag);

  assert_empty_read_R8: assert property (@(posedge clk) disable iff (!rstN)
    (dRd && fillCount == '0 && !resValid) |=> $stable(rdData) && fillCount == '0);

  assert_simul_R9: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && popping) |=> $stable(fillCount));
endmodule

bind sample_burst_fifo sample_burst_fifo_chk #(.DEPTH(DEPTH), .BUS_W(BUS_W)) u_chk (
  .clk(clk), .rstN(rstN), .resValid(resValid), .csN(csN), .rdN(rdN), .addr(addr),
  .fillCount(fillCount), .ovfFlag(ovfFlag), .lenCode(lenCode), .rdData(rdData)
);

// File: tb/sample_burst_fifo_bench.sv
module sample_burst_fifo_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        resValid = 1'b0;
  logic [11:0] resCode = '0;
  logic        resOor = 1'b0;
  logic        csN = 1'b1, rdN = 1'b1, wrN = 1'b1, addr = 1'b0;
  logic [2:0]  cfgData = '0;
  logic [15:0] rdData;
  logic        irq;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  int q[$];       // model: bit 12 = oor, [11:0] = code
  bit ovfM = 0;
  int lenM = 7;

  always #2 clk = ~clk;  // 250 MHz

  sample_burst_fifo u_sample_burst_fifo (
    .clk(clk), .rstN(rstN), .resValid(resValid), .resCode(resCode), .resOor(resOor),
    .csN(csN), .rdN(rdN), .wrN(wrN), .addr(addr), .cfgData(cfgData),
    .rdData(rdData), .irq(irq)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic int statExp();
    int hoor;
    hoor = (q.size() != 0) ? ((q[0] >> 12) & 1) : 0;
    return q.size() | ((q.size() == 0) << 4) | (hoor << 5) | (int'(ovfM) << 6) | (lenM << 7);
  endfunction

  // one bus/sample cycle: inputs set at negedge, released at next negedge
  task automatic cycle(bit doPush, int val, bit doRd, bit doWr, bit a, int cfg);
    @(negedge clk);
    resValid = doPush; resCode = val[11:0]; resOor = val[12];
    csN = !(doRd || doWr); rdN = !doRd; wrN = !doWr; addr = a; cfgData = cfg[2:0];
    @(negedge clk);
    resValid = 0; csN = 1; rdN = 1; wrN = 1;
  endtask

  task automatic modelPush(int val);
    if (q.size() >= lenM + 1) begin
      void'(q.pop_front());
      ovfM = 1;
    end
    q.push_back(val);
  endtask

  task automatic statusRead(string req);
    int e;
    e = statExp();
    cycle(0, 0, 1, 0, 1, 0);
    check(req, rdData, e);
    ovfM = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog R1 actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int lastRd;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 rdData", rdData, 0);
    check("R1 irq", irq, 0);
    statusRead("R1 status");

    // R10 / R2: every code passes through in order
    for (int c = 0; c < 4096; c++) begin
      int v;
      v = c | ((((c >> 11) ^ c) & 1) << 12);
      cycle(1, v, 0, 0, 0, 0);
      cycle(0, 0, 1, 0, 0, 0);
      check("R10 code sweep", rdData, v);
    end
    lastRd = rdData;

    // R8: empty data read holds rdData
    cycle(0, 0, 1, 0, 0, 0);
    check("R8 empty read", rdData, lastRd);
    statusRead("R8 count stays zero");

    // R4/R5/R6/R7/R3 across all lengths
    for (int lc = 0; lc < 8; lc++) begin
      cycle(0, 0, 0, 1, 1, lc);
      lenM = lc;
      check("R5 irq empty", irq, 0);
      for (int i = 0; i < lc + 3; i++) begin
        int v;
        v = ((lc * 37 + i * 11 + 5) & 12'hFFF) | ((i & 1) << 12);
        cycle(1, v, 0, 0, 0, 0);
        modelPush(v);
        check("R5 irq level", irq, (q.size() >= lenM + 1) ? 1 : 0);
      end
      statusRead("R6 R3 status after overwrite");
      statusRead("R7 overflow cleared");
      while (q.size() != 0) begin
        int e;
        e = q.pop_front();
        cycle(0, 0, 1, 0, 0, 0);
        check("R6 R2 order after overwrite", rdData, e);
        check("R5 irq after read", irq, (q.size() >= lenM + 1) ? 1 : 0);
      end
      cycle(0, 0, 1, 0, 0, 0);
      check("R8 empty read after drain", rdData, q.size() == 0 ? rdData : 0);
      statusRead("R3 empty status");
    end

    // R4: write to data port ignored; length code 5 then back to 7
    cycle(0, 0, 0, 1, 1, 5); lenM = 5;
    cycle(0, 0, 0, 1, 0, 0);
    statusRead("R4 data-port write ignored");
    cycle(0, 0, 0, 1, 1, 7); lenM = 7;

    // R9: push and read together on a full buffer
    for (int i = 0; i < 8; i++) begin
      cycle(1, 12'h100 + i, 0, 0, 0, 0);
      modelPush(12'h100 + i);
    end
    begin
      int e;
      e = q.pop_front();
      cycle(1, 13'h1ABC, 1, 0, 0, 0);
      q.push_back(13'h1ABC);
      check("R9 simultaneous read data", rdData, e);
    end
    statusRead("R9 count kept, no overflow");

    // R7: overwrite in same cycle as status read keeps flag set
    begin
      int e;
      e = statExp();
      cycle(1, 12'h0FFF, 1, 0, 1, 0);
      check("R7 status during overwrite", rdData, e);
      ovfM = 0;
      modelPush(12'h0FFF);
    end
    statusRead("R7 set wins over clear");
    while (q.size() != 0) begin
      int e;
      e = q.pop_front();
      cycle(0, 0, 1, 0, 0, 0);
      check("R10 R2 final drain", rdData, e);
    end
    statusRead("R3 final empty");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule